// File: doc/BRIEF.md
# Banked Program Counter Sequencer

This block produces the instruction-fetch address for a small 8-bit controller whose 16-bit-wide program memory holds 32768 words, split into four banks of 8192 words. Each cycle a decoded command tells the sequencer how to advance. It can step to the next word or skip one word. It can replace the low address byte, which gives a jump inside the current 256-word page. It can jump or call to a 13-bit target, with the two bank bits taken from a bank-pointer byte. It can return to an address held on an internal return stack. Enabled interrupt requests take priority over the command and send the fetch to a fixed vector.

Every change of flow discards the instruction that was already prefetched. The sequencer marks this by raising `dummy` for the cycle in which the new address is presented. The downstream pipeline treats the word arriving in that cycle as a bubble. The return stack is a parameterised LIFO, eight entries by default, and its full state is visible on `stk_full`.

Top module: `pc_seq`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, `fetch_addr` is 000H, `dummy` is 0 and `stk_full` is 0.
- R2: Command 0 (step) sets the next `fetch_addr` to the current address plus one. The address wraps at 15 bits and carries across bank boundaries. `dummy` is 0. Command codes 6 and 7 behave as command 0.
- R3: Command 1 (skip taken) sets the next address to the current address plus two and raises `dummy`.
- R4: Command 2 (low-byte write) keeps address bits 14:8 and loads bits 7:0 from `pcl_data`. It raises `dummy`.
- R5: Command 3 (jump) loads `{bank_ptr[6:5], tgt}`, where `bank_ptr[6:5]` = 00, 01, 10, 11 selects bank 0 to 3. The other bank-pointer bits have no effect. It raises `dummy`.
- R6: Command 4 (call) loads the same address as a jump, raises `dummy`, and pushes the current address plus one onto the return stack.
- R7: Command 5 (return) pops the full 15-bit address without consulting `bank_ptr`, and raises `dummy`.
- R8: An interrupt is taken when `irq_req & irq_en` is non-zero and the stack is not full. Bit 0 vectors to 004H, bit 1 to 008H and bit 2 to 00CH. The lowest set bit wins. The current address plus one is pushed, `dummy` rises, and the command is ignored for that cycle.
- R9: While `stk_full` is high, pending interrupts are refused and the command executes normally. `stk_full` is high exactly when `STACK_DEPTH` entries are held.
- R10: A call while the stack is full still jumps, but the push is suppressed and no held entry changes. A return while the stack is empty loads 000H.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op | input | 3 | Flow command: 0 step, 1 skip, 2 low-byte write, 3 jump, 4 call, 5 return |
| tgt | input | 13 | Jump/call target within a bank |
| pcl_data | input | 8 | New low address byte |
| bank_ptr | input | 8 | Bank-pointer byte; bits 6:5 select the bank |
| irq_req | input | 3 | Interrupt requests (bit 0 highest priority) |
| irq_en | input | 3 | Per-request enables |
| fetch_addr | output | 15 | Current fetch address |
| dummy | output | 1 | Prefetched word is discarded this cycle |
| stk_full | output | 1 | Return stack holds STACK_DEPTH entries |

## Verification
Several corner cases are targeted:
- A step from 5FFFH must cross into bank 3. A design that truncated to 13 bits would wrap back to bank 2.
- A low-byte write at a page's last word must keep the page bits. A full-width load would leave the page.
- A return issued with a different bank pointer must restore the saved bank. A design that reused `bank_ptr` would land in the wrong bank.
- Two simultaneous requests must select 008H rather than 00CH.
- With the stack filled, an interrupt must be refused and a further call must still jump. The eight returns that follow must come back in exact reverse order. A ninth return must give 000H, which exposes off-by-one pointers and overwritten entries.

// File: rtl/pc_seq.sv
module pc_seq #(
  parameter int TGT_W       = 13,
  parameter int BANK_W      = 2,
  parameter int BANK_LSB    = 5,
  parameter int PAGE_W      = 8,
  parameter int STACK_DEPTH = 8,
  parameter int NIRQ        = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [2:0]                op,
  input  logic [TGT_W-1:0]          tgt,
  input  logic [PAGE_W-1:0]         pcl_data,
  input  logic [7:0]                bank_ptr,
  input  logic [NIRQ-1:0]           irq_req,
  input  logic [NIRQ-1:0]           irq_en,
  output logic [BANK_W+TGT_W-1:0]   fetch_addr,
  output logic                      dummy,
  output logic                      stk_full
);
  localparam int AW   = BANK_W + TGT_W;
  localparam int SP_W = $clog2(STACK_DEPTH + 1);
  localparam int IX_W = $clog2(STACK_DEPTH);

  localparam logic [2:0] OP_SKIP = 3'd1, OP_PCLW = 3'd2, OP_JMP = 3'd3,
                         OP_CALL = 3'd4, OP_RET = 3'd5;

  logic [AW-1:0]   pc, pc_nx, inc, push_val, vec;
  logic [AW-1:0]   stk [STACK_DEPTH];
  logic [SP_W-1:0] sp, sp_m1;
  logic            empty, take_irq, do_push, do_pop, dum_nx;
  logic [NIRQ-1:0] pend;

  assign inc      = pc + AW'(1);
  assign sp_m1    = sp - SP_W'(1);
  assign stk_full = (sp == SP_W'(STACK_DEPTH));
  assign empty    = (sp == '0);
  assign pend     = irq_req & irq_en;
  assign take_irq = (|pend) && !stk_full;
  assign push_val = inc;

  always_comb begin
    vec = '0;
    for (int i = NIRQ - 1; i >= 0; i--)
      if (pend[i]) vec = AW'((i + 1) * 4);
  end

  always_comb begin
    pc_nx   = inc;
    dum_nx  = 1'b1;
    do_push = 1'b0;
    do_pop  = 1'b0;
    if (take_irq) begin
      pc_nx   = vec;
      do_push = 1'b1;
    end else begin
      case (op)
        OP_SKIP: pc_nx = pc + AW'(2);
        OP_PCLW: pc_nx = {pc[AW-1:PAGE_W], pcl_data};
        OP_JMP:  pc_nx = {bank_ptr[BANK_LSB +: BANK_W], tgt};
        OP_CALL: begin
          pc_nx   = {bank_ptr[BANK_LSB +: BANK_W], tgt};
          do_push = !stk_full;
        end
        OP_RET: begin
          pc_nx  = empty ? '0 : stk[sp_m1[IX_W-1:0]];
          do_pop = !empty;
        end
        default: dum_nx = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc    <= '0;
      dummy <= 1'b0;
      sp    <= '0;
    end else begin
      pc    <= pc_nx;
      dummy <= dum_nx;
      if (do_push)     sp <= sp + SP_W'(1);
      else if (do_pop) sp <= sp_m1;
    end
  end

  always_ff @(posedge clk)
    if (rst_n && do_push) stk[sp[IX_W-1:0]] <= push_val;

  assign fetch_addr = pc;
endmodule

// File: rtl/pc_seq_chk.sv
module pc_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [2:0]  op,
  input logic [12:0] tgt,
  input logic [7:0]  pcl_data,
  input logic [7:0]  bank_ptr,
  input logic [2:0]  irq_req,
  input logic [2:0]  irq_en,
  input logic [14:0] fetch_addr,
  input logic        dummy,
  input logic        stk_full
);
  logic no_irq, irq_go;
  assign no_irq = ((irq_req & irq_en) == 3'b0) || stk_full;
  assign irq_go = !no_irq;

  AST_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (no_irq && op == 3'd0) |=> (fetch_addr == $past(fetch_addr) + 15'd1) && !dummy); // R2
  AST_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
    (no_irq && op == 3'd1) |=> (fetch_addr == $past(fetch_addr) + 15'd2) && dummy); // R3
  AST_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
    (no_irq && op == 3'd2) |=> fetch_addr[14:8] == $past(fetch_addr[14:8]) && fetch_addr[7:0] == $past(pcl_data)); // R4
  AST_JUMP: assert property (@(posedge clk) disable iff (!rst_n)
    (no_irq && op == 3'd3) |=> fetch_addr == {$past(bank_ptr[6:5]), $past(tgt)} && dummy); // R5
  AST_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
    irq_go |=> dummy && (fetch_addr == 15'h004 || fetch_addr == 15'h008 || fetch_addr == 15'h00C)); // R8
  AST_PRIO: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_go && irq_req[0] && irq_en[0]) |=> fetch_addr == 15'h004); // R8
  AST_FULL_REFUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (stk_full && op == 3'd0) |=> fetch_addr == $past(fetch_addr) + 15'd1); // R9
endmodule

bind pc_seq pc_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .op(op), .tgt(tgt), .pcl_data(pcl_data),
  .bank_ptr(bank_ptr), .irq_req(irq_req), .irq_en(irq_en),
  .fetch_addr(fetch_addr), .dummy(dummy), .stk_full(stk_full)
);

// File: tb/pc_seq_tb.sv
module pc_seq_tb;
  logic        clk = 0, rst_n = 0;
  logic [2:0]  op = 0, irq_req = 0, irq_en = 0;
  logic [12:0] tgt = 0;
  logic [7:0]  pcl_data = 0, bank_ptr = 0;
  logic [14:0] fetch_addr;
  logic        dummy, stk_full;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  pc_seq u_dut (.clk(clk), .rst_n(rst_n), .op(op), .tgt(tgt), .pcl_data(pcl_data),
    .bank_ptr(bank_ptr), .irq_req(irq_req), .irq_en(irq_en),
    .fetch_addr(fetch_addr), .dummy(dummy), .stk_full(stk_full));

  typedef struct packed {
    logic [2:0]  op;
    logic [12:0] tgt;
    logic [7:0]  pcl;
    logic [7:0]  bp;
    logic [2:0]  irq;
    logic [14:0] ea;
    logic        ed;
    logic [7:0]  rq;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VT [NV] = '{
    '{3'd0, 13'h0,    8'h00, 8'h00, 3'b000, 15'h0001, 1'b0, 8'd2},  // R2
    '{3'd6, 13'h0,    8'h00, 8'h00, 3'b000, 15'h0002, 1'b0, 8'd2},  // R2
    '{3'd1, 13'h0,    8'h00, 8'h00, 3'b000, 15'h0004, 1'b1, 8'd3},  // R3
    '{3'd2, 13'h0,    8'h80, 8'h00, 3'b000, 15'h0080, 1'b1, 8'd4},  // R4
    '{3'd3, 13'h0123, 8'h00, 8'h20, 3'b000, 15'h2123, 1'b1, 8'd5},  // R5
    '{3'd3, 13'h1FFF, 8'h00, 8'hDF, 3'b000, 15'h5FFF, 1'b1, 8'd5},  // R5
    '{3'd0, 13'h0,    8'h00, 8'h00, 3'b000, 15'h6000, 1'b0, 8'd2},  // R2
    '{3'd4, 13'h0010, 8'h00, 8'h60, 3'b000, 15'h6010, 1'b1, 8'd6},  // R6
    '{3'd2, 13'h0,    8'hFF, 8'h00, 3'b000, 15'h60FF, 1'b1, 8'd4},  // R4
    '{3'd0, 13'h0,    8'h00, 8'h00, 3'b000, 15'h6100, 1'b0, 8'd2},  // R2
    '{3'd5, 13'h0,    8'h00, 8'h00, 3'b000, 15'h6001, 1'b1, 8'd7},  // R7
    '{3'd3, 13'h0555, 8'h00, 8'h00, 3'b110, 15'h0008, 1'b1, 8'd8},  // R8
    '{3'd0, 13'h0,    8'h00, 8'h00, 3'b000, 15'h0009, 1'b0, 8'd2},  // R2
    '{3'd5, 13'h0,    8'h00, 8'h00, 3'b000, 15'h6002, 1'b1, 8'd7},  // R7
    '{3'd5, 13'h0,    8'h00, 8'h00, 3'b000, 15'h0000, 1'b1, 8'd10}, // R10
    '{3'd0, 13'h0,    8'h00, 8'h00, 3'b100, 15'h000C, 1'b1, 8'd8},  // R8
    '{3'd5, 13'h0,    8'h00, 8'h00, 3'b000, 15'h0001, 1'b1, 8'd7}   // R7
  };

  task automatic chk(input string rq, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%0h exp=%0h", rq, got, exp);
    end
  endtask

  task automatic step(input logic [2:0] o, input logic [12:0] t, input logic [7:0] p,
                      input logic [7:0] b, input logic [2:0] rq, input logic [2:0] en);
    op = o; tgt = t; pcl_data = p; bank_ptr = b; irq_req = rq; irq_en = en;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 0; op = 0; irq_req = 0;
    @(posedge clk); @(negedge clk);
    chk("R1", {fetch_addr, dummy, stk_full}, 0);
    rst_n = 1;
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();
    step(3'd0, 0, 0, 0, 0, 0);
    chk("R1", fetch_addr, 15'h1);

    do_reset();
    for (int i = 0; i < NV; i++) begin
      step(VT[i].op, VT[i].tgt, VT[i].pcl, VT[i].bp, VT[i].irq, 3'b111);
      chk($sformatf("R%0d addr", VT[i].rq), fetch_addr, VT[i].ea);
      chk($sformatf("R%0d dummy", VT[i].rq), dummy, VT[i].ed);
    end

    // R8: masked request is ignored
    do_reset();
    step(3'd0, 0, 0, 0, 3'b001, 3'b000);
    chk("R8 masked", fetch_addr, 15'h1);

    // R9, R10: fill the stack, then refuse an interrupt and overflow a call
    do_reset();
    for (int i = 0; i < 8; i++) begin
      step(3'd4, 13'h100 + 13'(i), 0, 0, 0, 0);
      chk("R6 call", fetch_addr, 15'h100 + 15'(i));
    end
    chk("R9 full", stk_full, 1'b1);
    step(3'd0, 0, 0, 0, 3'b001, 3'b111);
    chk("R9 refused", fetch_addr, 15'h108);
    step(3'd4, 13'h1AAA, 0, 8'h00, 0, 0);
    chk("R10 call full", fetch_addr, 15'h1AAA);
    for (int i = 7; i >= 1; i--) begin
      step(3'd5, 0, 0, 8'h60, 0, 0);
      chk("R7 pop order", fetch_addr, 15'h100 + 15'(i));
      chk("R9 not full", stk_full, 1'b0);
    end
    step(3'd5, 0, 0, 8'h60, 0, 0);
    chk("R7 last pop", fetch_addr, 15'h1);
    step(3'd5, 0, 0, 0, 0, 0);
    chk("R10 empty pop", fetch_addr, 15'h0);

    // R1: reset in mid-run
    step(3'd3, 13'h0ABC, 0, 8'h40, 0, 0);
    do_reset();

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule